// File: doc/BRIEF.md
# Pushbutton Debounce and Single-Pulse Conditioner

This block cleans up a raw mechanical pushbutton so that control logic can use it. The button line is active-low (0 while pressed). It first passes through a two-flop synchronizer into the system clock domain. A slow sampling strobe, about 100 Hz and produced elsewhere from the system clock, then reads the synchronized line. A new debounced level is accepted only after a parameterized number of consecutive samples all disagree with the current level. Any sample that matches the current level restarts the count, so contact bounce never reaches the output.

The debounced level is active-low. It stays low for as long as the press lasts and goes high again only after the release passes the same agreement test. From that level the block derives a single-cycle pulse in the system clock domain, which is the domain of the consuming state machine. The pulse fires once per accepted press, however long the button is held, and never fires on a release.

Top module: `pb_press_cond`

## Requirements
- R1: The synchronized button is read only in cycles where `sample_en` is 1. With `sample_en` held at 0, the debounced level does not change, whatever `btn_raw_n` does.
- R2: A new level is accepted only on the SAMPLES-th consecutive sample (default 4) that differs from the current level. A sample equal to the current level clears the count, so shorter disagreeing runs have no effect.
- R3: When a press is accepted (SAMPLES consecutive samples with `btn_raw_n`=0), `btn_level_n` goes to 0 in the clock edge of that final sample.
- R4: `btn_level_n` stays 0 for as long as the button is held. It returns to 1 only after SAMPLES consecutive samples with `btn_raw_n`=1.
- R5: `press_pulse` is 1 for exactly one system clock cycle per accepted press, whatever the hold time. That cycle is the one that follows the edge where `btn_level_n` fell.
- R6: Accepting a release produces no pulse.
- R7: While `rst` is 1, and right after it, `btn_level_n` is 1, `press_pulse` is 0 and the agreement count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (consumer domain) |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw_n | input | 1 | Raw asynchronous button line, 0 = pressed |
| sample_en | input | 1 | One-cycle slow sampling strobe (about 100 Hz) |
| btn_level_n | output | 1 | Debounced level, 0 while a press is accepted |
| press_pulse | output | 1 | One-cycle pulse per accepted press |

## Verification
A raw change needs two system cycles to cross the synchronizer. The bench therefore holds each raw value for seven idle cycles before each strobe. It applies the strobe on a falling edge, so the level is due at the next rising edge, the one that carries the deciding sample. The pulse is due in the cycle after that edge. The bench counts pulses on every falling edge through the whole vector and checks the level two cycles after the last strobe, so an early, late, missing or repeated pulse all show up in the count.

// File: rtl/pb_cond_pkg.sv
package pb_cond_pkg;

    localparam int unsigned PB_CNT_W = 8;

    typedef struct packed {
        logic                level_n;
        logic [PB_CNT_W-1:0] agree_cnt;
    } pb_filt_t;

    localparam pb_filt_t PB_FILT_RST = '{level_n: 1'b1, agree_cnt: '0};

    function automatic logic [PB_CNT_W-1:0] pb_last_idx(input int unsigned samples);
        return PB_CNT_W'(samples - 1);
    endfunction

endpackage

// File: rtl/pb_sync2.sv
module pb_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            q_sync <= 1'b1;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/pb_agree_filter.sv
module pb_agree_filter
    import pb_cond_pkg::*;
#(
    parameter int unsigned SAMPLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic btn_sync_n,
    output logic level_n
);
    localparam logic [PB_CNT_W-1:0] LAST_IDX = pb_last_idx(SAMPLES);

    pb_filt_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PB_FILT_RST;
        end else if (sample_en) begin
            if (btn_sync_n == st_q.level_n) begin
                st_q.agree_cnt <= '0;
            end else if (st_q.agree_cnt == LAST_IDX) begin
                st_q.level_n   <= btn_sync_n;
                st_q.agree_cnt <= '0;
            end else begin
                st_q.agree_cnt <= st_q.agree_cnt + 1'b1;
            end
        end
    end

    assign level_n = st_q.level_n;

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.agree_cnt <= LAST_IDX); // R2
    AST_NO_SAMPLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(level_n)); // R1
    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sample_en && btn_sync_n == level_n) |=> (st_q.agree_cnt == '0)); // R2
endmodule

// File: rtl/pb_fall_pulse.sv
module pb_fall_pulse (
    input  logic clk,
    input  logic rst,
    input  logic level_n,
    output logic pulse
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b1;
        else     level_q <= level_n;
    end

    assign pulse = level_q & ~level_n;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R5
    AST_PULSE_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
        pulse |-> !level_n); // R6
endmodule

// File: rtl/pb_press_cond.sv
module pb_press_cond
    import pb_cond_pkg::*;
#(
    parameter int unsigned SAMPLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw_n,
    input  logic sample_en,
    output logic btn_level_n,
    output logic press_pulse
);
    logic btn_sync_n;

    pb_sync2 u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (btn_raw_n),
        .q_sync  (btn_sync_n)
    );

    pb_agree_filter #(.SAMPLES(SAMPLES)) u_filt (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (sample_en),
        .btn_sync_n (btn_sync_n),
        .level_n    (btn_level_n)
    );

    pb_fall_pulse u_pulse (
        .clk     (clk),
        .rst     (rst),
        .level_n (btn_level_n),
        .pulse   (press_pulse)
    );

    initial begin
        if (SAMPLES < 1 || SAMPLES > 255)
            $error("SAMPLES out of range");
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (btn_level_n && !press_pulse)); // R7
    AST_FALL_GIVES_PULSE: assert property (@(posedge clk) disable iff (rst)
        $fell(btn_level_n) |-> press_pulse); // R3
endmodule

// File: tb/pb_press_cond_tb.sv
`timescale 1ns/1ps
module pb_press_cond_tb;
    localparam int unsigned SAMPLES = 4;

    logic clk = 1'b0;
    logic rst, btn_raw_n, sample_en;
    logic btn_level_n, press_pulse;
    int   checks = 0, failures = 0, pulse_cnt = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    pb_press_cond #(.SAMPLES(SAMPLES)) u_dut (
        .clk(clk), .rst(rst), .btn_raw_n(btn_raw_n), .sample_en(sample_en),
        .btn_level_n(btn_level_n), .press_pulse(press_pulse)
    );

    always @(negedge clk) if (press_pulse) pulse_cnt++;

    typedef struct packed {
        logic       raw;
        logic [7:0] n_samp;
        logic       exp_lvl;
        logic [3:0] exp_pulses;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b0, 8'd3,  1'b1, 4'd0},   // R2: three lows only
        '{1'b1, 8'd2,  1'b1, 4'd0},   // R2: match clears count
        '{1'b0, 8'd3,  1'b1, 4'd0},   // R2: again short of four
        '{1'b0, 8'd1,  1'b0, 4'd1},   // R3 R5: fourth low accepted
        '{1'b0, 8'd20, 1'b0, 4'd0},   // R4 R5: long hold, no more pulses
        '{1'b1, 8'd3,  1'b0, 4'd0},   // R4: release not yet accepted
        '{1'b0, 8'd1,  1'b0, 4'd0},   // R2: bounce back resets release run
        '{1'b1, 8'd4,  1'b1, 4'd0},   // R4 R6: release, no pulse
        '{1'b0, 8'd4,  1'b0, 4'd1},   // R5: second press
        '{1'b1, 8'd4,  1'b1, 4'd0}    // R6: second release
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_samples(input int n);
        for (int i = 0; i < n; i++) begin
            repeat (7) @(negedge clk);
            sample_en = 1'b1;
            @(negedge clk);
            sample_en = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; btn_raw_n = 1'b1; sample_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 level after reset", 8'(btn_level_n), 8'd1);
        check("R7 pulse after reset", 8'(press_pulse), 8'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < 10; v++) begin
            pulse_cnt = 0;
            btn_raw_n = VEC[v].raw;
            run_samples(int'(VEC[v].n_samp));
            check($sformatf("R2/R3/R4 level vec %0d", v), 8'(btn_level_n), 8'(VEC[v].exp_lvl));
            check($sformatf("R5/R6 pulses vec %0d", v), 8'(pulse_cnt), 8'(VEC[v].exp_pulses));
        end

        // R1: raw held pressed for a long time with no strobe
        pulse_cnt = 0;
        btn_raw_n = 1'b0;
        repeat (60) @(negedge clk);
        check("R1 level without strobe", 8'(btn_level_n), 8'd1);
        check("R1 pulses without strobe", 8'(pulse_cnt), 8'd0);
        run_samples(SAMPLES);
        check("R1 level after strobes", 8'(btn_level_n), 8'd0);
        check("R5 pulse after strobes", 8'(pulse_cnt), 8'd1);

        // R7: reset while held clears level and count
        pulse_cnt = 0;
        do_reset();
        check("R7 level after mid-press reset", 8'(btn_level_n), 8'd1);
        check("R7 no pulse during reset", 8'(pulse_cnt), 8'd0);
        run_samples(SAMPLES - 1);
        check("R7 count cleared by reset", 8'(btn_level_n), 8'd1);
        run_samples(1);
        check("R3 press after reset", 8'(btn_level_n), 8'd0);
        check("R5 one pulse after reset", 8'(pulse_cnt), 8'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule